// File: doc/BRIEF.md
# Parallel Port Interface Adapter

This block is a memory-mapped parallel I/O peripheral with two independent 8-bit ports, A and B. Each port has an output latch, a per-bit direction register and a control register. It also has two control lines: line 1 is input-only, and line 2 can be an input or a driven output. A CPU reaches the four registers of the block through a 2-bit register select, a chip select and read and write strobes. Each port has an active-high interrupt request.

Each port takes two register offsets. The odd offset is the control register. The even offset reaches either the direction register or the data path, and control bit 2 chooses which. Control-line edges are brought into the clock domain by a synchroniser. Each control line has a two-state flag machine with the states FLG_IDLE and FLG_PEND. The transition FLG_IDLE to FLG_PEND ("edge seen") is taken on the selected edge of the synchronised line. The transition FLG_PEND to FLG_IDLE ("data read") is taken when the CPU reads the port's data register and no new edge arrives in the same cycle; a new edge in that cycle keeps the flag set. The interrupt output of a port combines the flags with their enable bits.

Top module: `pario_adapter`

## Requirements
- R1: After reset every register reads zero, every pin output enable is low, both interrupt outputs are low and line 2 of each port is undriven.
- R2: Register select 0 is port A even, 1 is port A control, 2 is port B even and 3 is port B control. A read strobe returns its value on `rdata` one clock later, and the two ports do not affect each other.
- R3: Control bit 2 set to 0 maps the even offset to the direction register. Set to 1, it maps the even offset to the data path, and a write there loads the output latch.
- R4: Direction bit n equal to 1 makes pin n an output: its output enable is high and it drives latch bit n. A value of 0 makes pin n an input.
- R5: A data read returns latch bits for output pins and the synchronised pin level for input pins.
- R6: Control bit 7 (line 1 flag) sets on the line 1 edge chosen by control bit 1 (0 falling, 1 rising), whether or not enable bit 0 is set.
- R7: With control bit 5 at 0, control bit 6 (line 2 flag) sets on the line 2 edge chosen by control bit 4 (0 falling, 1 rising). Control bit 3 enables its interrupt.
- R8: With control bit 5 at 1, line 2 is driven (output enable high) to the value of control bit 4, and edges on line 2 do not set the flag.
- R9: A port's interrupt output is high exactly when (bit 7 and bit 0) or (bit 6 and bit 3 and not bit 5) of its control register hold.
- R10: A data read (even offset with bit 2 at 1) clears both flags of that port. A control write changes only bits 5 to 0, never the flags.
- R11: With chip select low, read and write strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rs | input | 2 | Register select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_a | output | 1 | Port A interrupt request |
| irq_b | output | 1 | Port B interrupt request |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-bit output enable |
| pa_l1 | input | 1 | Port A control line 1 |
| pa_l2_in | input | 1 | Port A control line 2 input level |
| pa_l2_out | output | 1 | Port A control line 2 output level |
| pa_l2_oe | output | 1 | Port A control line 2 output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-bit output enable |
| pb_l1 | input | 1 | Port B control line 1 |
| pb_l2_in | input | 1 | Port B control line 2 input level |
| pb_l2_out | output | 1 | Port B control line 2 output level |
| pb_l2_oe | output | 1 | Port B control line 2 output enable |

## Verification
A register write shows up on the latch, direction and line 2 outputs at the first edge, and the interrupt output follows in the same cycle. Read data is registered, so the monitor compares `rdata` at the falling edge one clock after the strobe and pops the expected value that the driver queued when it issued that read. A pin or control-line change needs two synchroniser edges and one edge-detect edge before a flag or the read-back level moves. The bench therefore waits at least four full cycles after every pin stimulus before it reads or checks an interrupt output.

// File: rtl/pario_pkg.sv
package pario_pkg;
    localparam int BUS_W      = 8;
    localparam int CTL_FIELDS = 6;
    localparam int NPORT      = 2;

    // writable control fields, packed to match bits 5..0 of the control word
    typedef struct packed {
        logic dir2;   // line 2 driven when 1
        logic lvl2;   // line 2 edge select / driven level
        logic en2;    // line 2 interrupt enable
        logic sel;    // even offset: 0 direction, 1 data
        logic pol1;   // line 1 edge select
        logic en1;    // line 1 interrupt enable
    } ctl_bits_t;

    typedef enum logic [0:0] {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_t;
endpackage

// File: rtl/pario_sync.sv
module pario_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pario_ctl_line.sv
module pario_ctl_line
    import pario_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,     // synchronised line level
    input  logic rise_sel,   // 1 rising, 0 falling
    input  logic accept,     // edges counted only when high
    input  logic clear,      // data-register read
    output logic flag
);
    flag_state_t state, state_nx;
    logic        prev;
    logic        hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= line_s;
    end

    always_comb begin
        hit = accept && (rise_sel ? (line_s && !prev) : (!line_s && prev));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FLG_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FLG_IDLE: if (hit)            state_nx = FLG_PEND;
            FLG_PEND: if (clear && !hit)  state_nx = FLG_IDLE;
            default:                      state_nx = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag = (state == FLG_PEND);
    end
endmodule

// File: rtl/pario_port.sv
module pario_port
    import pario_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_even,
    input  logic             wr_odd,
    input  logic             rd_even,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] even_val,
    output logic [BUS_W-1:0] ctl_view,
    input  logic [BUS_W-1:0] pin_in,
    output logic [BUS_W-1:0] pin_out,
    output logic [BUS_W-1:0] pin_oe,
    input  logic             l1_in,
    input  logic             l2_in,
    output logic             l2_out,
    output logic             l2_oe,
    output logic             irq
);
    localparam int SW = BUS_W + 2;

    ctl_bits_t        cfg;
    logic [BUS_W-1:0] dir_q;
    logic [BUS_W-1:0] lat_q;
    logic [SW-1:0]    sync_q;
    logic [BUS_W-1:0] pin_s;
    logic             l1_s, l2_s;
    logic             flag1, flag2;
    logic             data_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg   <= '0;
            dir_q <= '0;
            lat_q <= '0;
        end else begin
            if (wr_odd) cfg <= ctl_bits_t'(wdata[CTL_FIELDS-1:0]);
            if (wr_even) begin
                if (cfg.sel) lat_q <= wdata;
                else         dir_q <= wdata;
            end
        end
    end

    pario_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({l2_in, l1_in, pin_in}),
        .q     (sync_q)
    );

    assign pin_s = sync_q[BUS_W-1:0];
    assign l1_s  = sync_q[BUS_W];
    assign l2_s  = sync_q[BUS_W+1];

    assign data_rd = rd_even && cfg.sel;

    pario_ctl_line u_line1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_s   (l1_s),
        .rise_sel (cfg.pol1),
        .accept   (1'b1),
        .clear    (data_rd),
        .flag     (flag1)
    );

    pario_ctl_line u_line2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_s   (l2_s),
        .rise_sel (cfg.lvl2),
        .accept   (!cfg.dir2),
        .clear    (data_rd),
        .flag     (flag2)
    );

    always_comb begin
        if (cfg.sel) even_val = (lat_q & dir_q) | (pin_s & ~dir_q);
        else         even_val = dir_q;
        ctl_view = {flag1, flag2, cfg};
        irq      = (flag1 && cfg.en1) || (flag2 && cfg.en2 && !cfg.dir2);
    end

    assign pin_out = lat_q;
    assign pin_oe  = dir_q;
    assign l2_out  = cfg.lvl2;
    assign l2_oe   = cfg.dir2;
endmodule

// File: rtl/pario_adapter.sv
module pario_adapter
    import pario_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic [1:0]       rs,
    input  logic             wr,
    input  logic             rd,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             irq_a,
    output logic             irq_b,
    input  logic [BUS_W-1:0] pa_in,
    output logic [BUS_W-1:0] pa_out,
    output logic [BUS_W-1:0] pa_oe,
    input  logic             pa_l1,
    input  logic             pa_l2_in,
    output logic             pa_l2_out,
    output logic             pa_l2_oe,
    input  logic [BUS_W-1:0] pb_in,
    output logic [BUS_W-1:0] pb_out,
    output logic [BUS_W-1:0] pb_oe,
    input  logic             pb_l1,
    input  logic             pb_l2_in,
    output logic             pb_l2_out,
    output logic             pb_l2_oe
);
    logic [NPORT-1:0][BUS_W-1:0] pin_in_v, pin_out_v, pin_oe_v, even_v, ctl_view;
    logic [NPORT-1:0]            l1_v, l2_v, l2o_v, l2oe_v, irq_v;
    logic [NPORT-1:0]            wr_e, wr_o, rd_e;
    logic [BUS_W-1:0]            rd_val;

    assign pin_in_v = {pb_in, pa_in};
    assign l1_v     = {pb_l1, pa_l1};
    assign l2_v     = {pb_l2_in, pa_l2_in};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam logic [1:0] EVEN_RS = 2'(2 * p);
        localparam logic [1:0] ODD_RS  = 2'(2 * p + 1);

        assign wr_e[p] = cs && wr && (rs == EVEN_RS);
        assign wr_o[p] = cs && wr && (rs == ODD_RS);
        assign rd_e[p] = cs && rd && (rs == EVEN_RS);

        pario_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_even  (wr_e[p]),
            .wr_odd   (wr_o[p]),
            .rd_even  (rd_e[p]),
            .wdata    (wdata),
            .even_val (even_v[p]),
            .ctl_view (ctl_view[p]),
            .pin_in   (pin_in_v[p]),
            .pin_out  (pin_out_v[p]),
            .pin_oe   (pin_oe_v[p]),
            .l1_in    (l1_v[p]),
            .l2_in    (l2_v[p]),
            .l2_out   (l2o_v[p]),
            .l2_oe    (l2oe_v[p]),
            .irq      (irq_v[p])
        );
    end

    always_comb begin
        rd_val = rs[0] ? ctl_view[rs[1]] : even_v[rs[1]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rdata <= '0;
        else if (cs && rd) rdata <= rd_val;
    end

    assign pa_out    = pin_out_v[0];
    assign pa_oe     = pin_oe_v[0];
    assign pa_l2_out = l2o_v[0];
    assign pa_l2_oe  = l2oe_v[0];
    assign pb_out    = pin_out_v[1];
    assign pb_oe     = pin_oe_v[1];
    assign pb_l2_out = l2o_v[1];
    assign pb_l2_oe  = l2oe_v[1];
    assign irq_a     = irq_v[0];
    assign irq_b     = irq_v[1];
endmodule

// File: rtl/pario_checker.sv
module pario_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs,
    input logic       wr,
    input logic [1:0] rs,
    input logic [7:0] wdata,
    input logic       irq_a,
    input logic       irq_b,
    input logic [7:0] a_oe,
    input logic [7:0] a_out,
    input logic [7:0] ctl_a,
    input logic [7:0] ctl_b
);
    a_r4_dir_drives_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && rs == 2'd0 && !ctl_a[2]) |=> (a_oe == $past(wdata)));

    a_r3_data_loads_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && rs == 2'd0 && ctl_a[2]) |=> (a_out == $past(wdata)));

    a_r10_ctl_write_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && rs == 2'd1) |=> ((~ctl_a[7:6] & $past(ctl_a[7:6])) == 2'b00));

    a_r8_no_flag_when_driven: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_b[5]) |-> !$rose(ctl_b[6]));

    a_r9_irq_a_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a |-> (ctl_a[7] || ctl_a[6]));

    a_r9_irq_b_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_b |-> (ctl_b[7] || ctl_b[6]));

    a_r11_idle_without_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> ($stable(a_oe) && $stable(a_out) && $stable(ctl_a[5:0])));
endmodule

bind pario_adapter pario_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs    (cs),
    .wr    (wr),
    .rs    (rs),
    .wdata (wdata),
    .irq_a (irq_a),
    .irq_b (irq_b),
    .a_oe  (pa_oe),
    .a_out (pa_out),
    .ctl_a (ctl_view[0]),
    .ctl_b (ctl_view[1])
);

// File: tb/pario_adapter_test.sv
`timescale 1ns/1ps
module pario_adapter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [1:0] rs = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_a, irq_b;
    logic [7:0] pa_in = 8'h00, pa_out, pa_oe;
    logic       pa_l1 = 1'b0, pa_l2_in = 1'b0, pa_l2_out, pa_l2_oe;
    logic [7:0] pb_in = 8'h00, pb_out, pb_oe;
    logic       pb_l1 = 1'b0, pb_l2_in = 1'b0, pb_l2_out, pb_l2_oe;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    logic rd_d = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    pario_adapter uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rs(rs), .wr(wr), .rd(rd),
        .wdata(wdata), .rdata(rdata), .irq_a(irq_a), .irq_b(irq_b),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pa_l1(pa_l1),
        .pa_l2_in(pa_l2_in), .pa_l2_out(pa_l2_out), .pa_l2_oe(pa_l2_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pb_l1(pb_l1),
        .pb_l2_in(pb_l2_in), .pb_l2_out(pb_l2_out), .pb_l2_oe(pb_l2_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: a read strobe seen at an edge has its data due by the next falling edge
    always @(posedge clk) rd_d <= cs & rd;

    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R2: unexpected read data %02h expected none", rdata);
            end else begin
                chk(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
        @(negedge clk);
        cs = sel; wr = 1'b1; rs = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; rs = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pa_oe", pa_oe, 8'h00);
        chk("R1 pb_oe", pb_oe, 8'h00);
        chk("R1 irq", {6'd0, irq_b, irq_a}, 8'h00);
        chk("R1 l2_oe", {6'd0, pb_l2_oe, pa_l2_oe}, 8'h00);
        bus_rd(2'd1, 8'h00, "R1 ctl A");
        bus_rd(2'd3, 8'h00, "R1 ctl B");
        bus_rd(2'd0, 8'h00, "R1 dir A");

        // R3/R4 direction via even offset with bit2 clear
        bus_wr(2'd0, 8'hF0);
        chk("R4 pa_oe", pa_oe, 8'hF0);
        bus_rd(2'd0, 8'hF0, "R3 dir readback");
        bus_wr(2'd1, 8'h04);
        bus_wr(2'd0, 8'hA5);
        chk("R3 latch", pa_out, 8'hA5);
        chk("R3 dir kept", pa_oe, 8'hF0);

        // R5 mixed read
        pa_in = 8'h3C;
        settle();
        bus_rd(2'd0, 8'hAC, "R5 mixed read");
        bus_rd(2'd1, 8'h04, "R2 ctl A");

        // R2 port B independent
        bus_wr(2'd2, 8'h0F);
        chk("R2 pb_oe", pb_oe, 8'h0F);
        chk("R2 pa_oe untouched", pa_oe, 8'hF0);

        // R6/R9 line 1 rising, enabled
        bus_wr(2'd1, 8'h07);
        pa_l1 = 1'b1;
        settle();
        chk("R9 irq_a set", {7'd0, irq_a}, 8'h01);
        bus_rd(2'd1, 8'h87, "R6 flag1 rising");
        bus_rd(2'd0, 8'hAC, "R10 data read");
        chk("R10 irq_a cleared", {7'd0, irq_a}, 8'h00);
        bus_rd(2'd1, 8'h07, "R10 flags cleared");

        // R6 falling, disabled: flag still sets, no irq
        bus_wr(2'd1, 8'h04);
        pa_l1 = 1'b0;
        settle();
        chk("R9 irq_a masked", {7'd0, irq_a}, 8'h00);
        bus_rd(2'd1, 8'h84, "R6 flag1 falling");
        bus_wr(2'd1, 8'hC4);
        bus_rd(2'd1, 8'h84, "R10 write keeps flags");
        bus_wr(2'd1, 8'h05);
        chk("R9 irq_a on enable", {7'd0, irq_a}, 8'h01);
        bus_rd(2'd0, 8'hAC, "R10 data read 2");
        chk("R10 irq_a cleared 2", {7'd0, irq_a}, 8'h00);

        // R7 line 2 input on port B
        bus_wr(2'd3, 8'h1C);
        chk("R7 l2 undriven", {7'd0, pb_l2_oe}, 8'h00);
        pb_l2_in = 1'b1;
        settle();
        chk("R7 irq_b", {7'd0, irq_b}, 8'h01);
        bus_rd(2'd3, 8'h5C, "R7 flag2 rising");
        bus_rd(2'd2, 8'h00, "R10 B data read");
        chk("R10 irq_b cleared", {7'd0, irq_b}, 8'h00);

        // R8 line 2 output
        bus_wr(2'd3, 8'h3C);
        chk("R8 drive high", {6'd0, pb_l2_oe, pb_l2_out}, 8'h03);
        bus_wr(2'd3, 8'h2C);
        chk("R8 drive low", {6'd0, pb_l2_oe, pb_l2_out}, 8'h02);
        pb_l2_in = 1'b0;
        settle();
        pb_l2_in = 1'b1;
        settle();
        bus_rd(2'd3, 8'h2C, "R8 edges ignored");
        chk("R8 irq_b quiet", {7'd0, irq_b}, 8'h00);

        // R11 strobes without chip select
        bus_wr(2'd0, 8'hFF, 1'b0);
        bus_wr(2'd1, 8'h00, 1'b0);
        @(negedge clk);
        rd = 1'b1; rs = 2'd0;
        @(negedge clk);
        rd = 1'b0;
        chk("R11 latch kept", pa_out, 8'hA5);
        chk("R11 dir kept", pa_oe, 8'hF0);
        chk("R11 rdata kept", rdata, 8'h2C);
        bus_rd(2'd1, 8'h05, "R11 ctl kept");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2: pending reads %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule